// File: doc/BRIEF.md
# Interrupt Priority Register File

This block holds one priority byte for each external interrupt line and for each configurable system exception of an interrupt controller. Software reaches it through a word-wide register port with per-byte enables and a secure attribute. The port exposes two windows: one addresses a single vector per byte, and the other maps the system-handler priority bytes onto internal exception slots 4 to 15. The full priority table is also driven out as a flat read-only vector, so a neighbouring arbiter can choose between pending interrupts. A one-cycle strobe tells that arbiter when a stored priority has changed.

Each written byte keeps only its implemented high-order bits. Lanes that land past the configured interrupt count, or on an interrupt that belongs to the secure state during a non-secure access, are dropped. In the reduced profile only two priority bits exist, and the first system-handler word is inert.

Top module: `prio_regfile`

## Requirements
- R1: Reset clears every stored priority byte to zero, clears the update strobe and clears the read data.
- R2: A written priority keeps only its top PRIO_BITS bits and its lower bits read back as zero. PRIO_BITS is 8 when FULL_PROFILE is 1 and 2 when it is 0.
- R3: Byte lane i (i = 0..3) of an access at word address W addresses byte offset 4*W+i and carries acc_wdata_i[8i+7:8i]. A write updates a lane only when acc_be_i[i] is set. A read returns all four lanes in acc_rdata_o at the same byte positions. Offsets 0x400 to 0x5EF each select vector (offset - 0x400) + 16.
- R4: A lane in the interrupt window whose vector is at or above NUM_EXT + 16 ignores writes and reads as zero.
- R5: A non-secure access (acc_secure_i = 0) to interrupt vector v reads and writes it only when irq_ns_i[v-16] is 1. Otherwise the write is ignored and the lane reads zero. Secure accesses are not filtered.
- R6: Offsets 0xD18 to 0xD23 select internal exception (offset - 0xD14), which covers slots 4 to 15, with no security filter.
- R7: When FULL_PROFILE is 0, offsets 0xD18 to 0xD1B read as zero and ignore writes, while 0xD1C to 0xD23 keep working.
- R8: Slots 0 to 3 (the fixed exceptions and the unused slot below the first configurable handler) are never written and stay zero. Offsets 0xD14 to 0xD17 and all other offsets outside both windows read zero.
- R9: prio_upd_o is high for exactly the one cycle after a write that changed at least one stored byte. It stays low after a write that changes nothing or is ignored.
- R10: prio_o holds vector v's priority at bits [8v+7:8v] and shows a write from the cycle after it. acc_rdata_o is registered and shows a read's data from the cycle after the read, and reads do not alter any priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access request this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_secure_i | input | 1 | Secure attribute of the access |
| acc_waddr_i | input | 10 | Word address (byte offset divided by 4) |
| acc_be_i | input | 4 | Byte-lane write enables |
| acc_wdata_i | input | 32 | Write data, lane i in bits [8i+7:8i] |
| irq_ns_i | input | NUM_EXT | Per-interrupt target-non-secure bits |
| acc_rdata_o | output | 32 | Registered read data |
| prio_o | output | (NUM_EXT+16)*8 | All stored priorities, one byte per vector |
| prio_upd_o | output | 1 | One-cycle pulse after a priority change |

## Verification
A write is taken on a rising edge. Its effect on prio_o and the update pulse both appear in the cycle that follows, and read data for a read issued in cycle N is held from the edge that ends cycle N. The bench drives each access on a falling edge and removes the request on the next falling edge. It samples prio_o, prio_upd_o and acc_rdata_o at that second falling edge, one register stage after the request. It samples the update strobe once more a cycle later to confirm that the pulse has ended.

// File: rtl/iprf_pkg.sv
package iprf_pkg;

  localparam int FIRST_EXT = 16;
  localparam int NMI_NUM   = 2;
  localparam int MAX_EXT   = 496;
  localparam int LANES     = 4;

  localparam logic [11:0] IRQ_LO    = 12'h400;
  localparam logic [11:0] IRQ_HI    = 12'h5EF;
  localparam logic [11:0] SHP_LO    = 12'hD18;
  localparam logic [11:0] SHP_HI    = 12'hD23;
  localparam logic [11:0] SHP_BIAS  = 12'hD14;
  localparam logic [11:0] SHP_W0_HI = 12'hD1B;

  typedef logic [7:0] prio_t;

  // byte offset of one lane of a word access
  function automatic logic [11:0] lane_off(input logic [9:0] waddr, input int lane);
    return {waddr, 2'(lane)};
  endfunction

  // keep the top 'bits' bits of a priority byte
  function automatic prio_t prio_mask(input int bits);
    return ~(8'hFF >> bits);
  endfunction

  function automatic logic in_window(input logic [11:0] off, input logic [11:0] lo,
                                     input logic [11:0] hi);
    return (off >= lo) && (off <= hi);
  endfunction

  // external line number addressed by an interrupt-window offset
  function automatic logic [11:0] ext_line(input logic [11:0] off);
    return off - IRQ_LO;
  endfunction

  // internal exception slot addressed by a system-handler offset
  function automatic logic [11:0] shp_slot(input logic [11:0] off);
    return off - SHP_BIAS;
  endfunction

endpackage

// File: rtl/iprf_lane_dec.sv
module iprf_lane_dec
  import iprf_pkg::*;
#(
  parameter int NUM_EXT      = 32,
  parameter bit FULL_PROFILE = 1'b1,
  parameter int LANE         = 0,
  parameter int VEC_W        = $clog2(NUM_EXT + FIRST_EXT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [9:0]         waddr_i,
  input  logic               secure_i,
  input  logic [NUM_EXT-1:0] irq_ns_i,
  output logic               hit_o,
  output logic [VEC_W-1:0]   vec_o
);

  localparam int NUM_VEC = NUM_EXT + FIRST_EXT;
  localparam int EXT_W   = (NUM_EXT > 1) ? $clog2(NUM_EXT) : 1;
  localparam logic [11:0] NUM_EXT_12 = 12'(NUM_EXT);
  localparam logic [11:0] NMI_12     = 12'(NMI_NUM);
  localparam logic [11:0] FIRST_12   = 12'(FIRST_EXT);

  logic [11:0] off;
  logic [11:0] ext_idx;
  logic [11:0] slot_idx;
  logic        in_irq;
  logic        in_shp;
  logic        shp_open;
  logic        ns_ok;

  always_comb begin
    off      = lane_off(waddr_i, LANE);
    in_irq   = in_window(off, IRQ_LO, IRQ_HI);
    in_shp   = in_window(off, SHP_LO, SHP_HI);
    shp_open = FULL_PROFILE || (off > SHP_W0_HI);
    ext_idx  = ext_line(off);
    slot_idx = shp_slot(off);
    ns_ok    = 1'b0;
    if (ext_idx < NUM_EXT_12) ns_ok = irq_ns_i[ext_idx[EXT_W-1:0]];
    hit_o = 1'b0;
    vec_o = '0;
    if (in_irq) begin
      hit_o = (ext_idx < NUM_EXT_12) && (secure_i || ns_ok);
      vec_o = VEC_W'(ext_idx + FIRST_12);
    end else if (in_shp && shp_open) begin
      hit_o = slot_idx > NMI_12;
      vec_o = VEC_W'(slot_idx);
    end
  end

  // a selected lane always names an implemented vector
  assert_vec_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (int'(vec_o) < NUM_VEC));

  // fixed-priority exceptions are never selected
  assert_fixed_untouched_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (int'(vec_o) > NMI_NUM));

endmodule

// File: rtl/iprf_store.sv
module iprf_store
  import iprf_pkg::*;
#(
  parameter int NUM_VEC   = 48,
  parameter int PRIO_BITS = 8,
  parameter int VEC_W     = $clog2(NUM_VEC)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LANES-1:0]     wr_en_i,
  input  logic [VEC_W-1:0]     vec_i   [LANES],
  input  prio_t                wbyte_i [LANES],
  output prio_t                cur_o   [LANES],
  output logic                 change_o,
  output logic [NUM_VEC*8-1:0] prio_o
);

  localparam prio_t MASK = prio_mask(PRIO_BITS);

  prio_t prio_arr [NUM_VEC];

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    localparam bit WRITABLE = (v > NMI_NUM);
    prio_t q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else begin
        for (int l = 0; l < LANES; l++) begin
          if (WRITABLE && wr_en_i[l] && (vec_i[l] == VEC_W'(v))) q <= wbyte_i[l] & MASK;
        end
      end
    end

    assign prio_arr[v]      = q;
    assign prio_o[8*v +: 8] = q;

    // unimplemented low bits never hold a one
    assert_low_bits_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q & ~MASK) == 8'h00);
  end

  always_comb begin
    change_o = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      cur_o[l] = prio_arr[vec_i[l]];
      if (wr_en_i[l] && ((wbyte_i[l] & MASK) != cur_o[l])) change_o = 1'b1;
    end
  end

endmodule

// File: rtl/prio_regfile.sv
module prio_regfile
  import iprf_pkg::*;
#(
  parameter int NUM_EXT      = 32,
  parameter bit FULL_PROFILE = 1'b1,
  parameter int PRIO_BITS    = FULL_PROFILE ? 8 : 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             acc_valid_i,
  input  logic                             acc_write_i,
  input  logic                             acc_secure_i,
  input  logic [9:0]                       acc_waddr_i,
  input  logic [3:0]                       acc_be_i,
  input  logic [31:0]                      acc_wdata_i,
  input  logic [NUM_EXT-1:0]               irq_ns_i,
  output logic [31:0]                      acc_rdata_o,
  output logic [(NUM_EXT+FIRST_EXT)*8-1:0] prio_o,
  output logic                             prio_upd_o
);

  localparam int NUM_VEC = NUM_EXT + FIRST_EXT;
  localparam int VEC_W   = $clog2(NUM_VEC);

  logic [LANES-1:0] lane_hit;
  logic [VEC_W-1:0] lane_vec [LANES];
  logic [LANES-1:0] wr_en;
  prio_t            wbyte    [LANES];
  prio_t            cur      [LANES];
  logic             change;
  logic [31:0]      rdata_q;
  logic             upd_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    iprf_lane_dec #(
      .NUM_EXT      (NUM_EXT),
      .FULL_PROFILE (FULL_PROFILE),
      .LANE         (l),
      .VEC_W        (VEC_W)
    ) u_dec (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .waddr_i  (acc_waddr_i),
      .secure_i (acc_secure_i),
      .irq_ns_i (irq_ns_i),
      .hit_o    (lane_hit[l]),
      .vec_o    (lane_vec[l])
    );
    assign wbyte[l] = acc_wdata_i[8*l +: 8];
    assign wr_en[l] = acc_valid_i & acc_write_i & acc_be_i[l] & lane_hit[l];
  end

  iprf_store #(
    .NUM_VEC   (NUM_VEC),
    .PRIO_BITS (PRIO_BITS),
    .VEC_W     (VEC_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .vec_i    (lane_vec),
    .wbyte_i  (wbyte),
    .cur_o    (cur),
    .change_o (change),
    .prio_o   (prio_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= change;
      if (acc_valid_i && !acc_write_i) begin
        for (int l = 0; l < LANES; l++) rdata_q[8*l +: 8] <= lane_hit[l] ? cur[l] : 8'h00;
      end
    end
  end

  assign acc_rdata_o = rdata_q;
  assign prio_upd_o  = upd_q;

  // every change of the table is announced
  assert_upd_on_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio_o != $past(prio_o)) |-> prio_upd_o);

  // the strobe only follows a write request
  assert_upd_after_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prio_upd_o |-> $past(acc_valid_i && acc_write_i));

  // without a write the table holds
  assert_read_no_effect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!(acc_valid_i && acc_write_i)) |-> $stable(prio_o));

endmodule

// File: tb/prio_regfile_bench.sv
module prio_regfile_bench;

  localparam int NUM_EXT = 32;
  localparam int NUM_VEC = NUM_EXT + 16;
  localparam int NROW    = 23;

  // {write, secure, byte addr, be, wdata, expected full, expected reduced}
  localparam logic [113:0] TBL [NROW] = '{
    {1'b1, 1'b1, 12'h400, 4'hF, 32'hA55A3CFF, 32'h0, 32'h0},
    {1'b0, 1'b1, 12'h400, 4'hF, 32'h0, 32'hA55A3CFF, 32'h804000C0},        // R2 R3
    {1'b1, 1'b0, 12'h404, 4'hF, 32'h11223344, 32'h0, 32'h0},
    {1'b0, 1'b0, 12'h404, 4'hF, 32'h0, 32'h11223344, 32'h00000040},        // R5 ns allowed
    {1'b1, 1'b0, 12'h400, 4'hF, 32'h00000000, 32'h0, 32'h0},
    {1'b0, 1'b1, 12'h400, 4'hF, 32'h0, 32'hA55A3CFF, 32'h804000C0},        // R5 write ignored
    {1'b0, 1'b0, 12'h400, 4'hF, 32'h0, 32'h0, 32'h0},                      // R5 read zero
    {1'b1, 1'b1, 12'h41C, 4'hF, 32'hDEADBEEF, 32'h0, 32'h0},
    {1'b0, 1'b1, 12'h41C, 4'hF, 32'h0, 32'hDEADBEEF, 32'hC08080C0},        // R3 last vectors
    {1'b1, 1'b1, 12'h420, 4'hF, 32'hFFFFFFFF, 32'h0, 32'h0},
    {1'b0, 1'b1, 12'h420, 4'hF, 32'h0, 32'h0, 32'h0},                      // R4 out of range
    {1'b1, 1'b1, 12'h408, 4'h6, 32'h77665544, 32'h0, 32'h0},
    {1'b0, 1'b1, 12'h408, 4'hF, 32'h0, 32'h00665500, 32'h00404000},        // R3 byte enables
    {1'b1, 1'b1, 12'hD18, 4'hF, 32'h80706050, 32'h0, 32'h0},
    {1'b0, 1'b1, 12'hD18, 4'hF, 32'h0, 32'h80706050, 32'h00000000},        // R7 first word
    {1'b1, 1'b1, 12'hD1C, 4'hF, 32'h12345678, 32'h0, 32'h0},
    {1'b0, 1'b0, 12'hD1C, 4'hF, 32'h0, 32'h12345678, 32'h00004040},        // R6 no filter
    {1'b1, 1'b1, 12'hD20, 4'hF, 32'hFFC08040, 32'h0, 32'h0},
    {1'b0, 1'b1, 12'hD20, 4'hF, 32'h0, 32'hFFC08040, 32'hC0C08040},        // R2 R6
    {1'b1, 1'b1, 12'hD14, 4'hF, 32'hFFFFFFFF, 32'h0, 32'h0},
    {1'b0, 1'b1, 12'hD14, 4'hF, 32'h0, 32'h0, 32'h0},                      // R8
    {1'b0, 1'b1, 12'h000, 4'hF, 32'h0, 32'h0, 32'h0},                      // R10 unmapped
    {1'b0, 1'b1, 12'h5EC, 4'hF, 32'h0, 32'h0, 32'h0}                       // R4 window end
  };
  localparam int TAG [NROW] = '{0, 2, 0, 5, 0, 5, 5, 0, 3, 0, 4, 0, 3, 0, 7, 0, 6, 0, 6, 0, 8, 10, 4};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        write = 1'b0;
  logic        secure = 1'b0;
  logic [9:0]  waddr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [NUM_EXT-1:0] ns_bits = 32'h0000_00F0;   // lines 4..7 target non-secure

  logic [31:0]          rdata_f, rdata_r;
  logic [NUM_VEC*8-1:0] prio_f, prio_r;
  logic                 upd_f, upd_r;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  prio_regfile #(.NUM_EXT(NUM_EXT), .FULL_PROFILE(1'b1)) u_prio_regfile (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_write_i(write),
    .acc_secure_i(secure), .acc_waddr_i(waddr), .acc_be_i(be), .acc_wdata_i(wdata),
    .irq_ns_i(ns_bits), .acc_rdata_o(rdata_f), .prio_o(prio_f), .prio_upd_o(upd_f));

  prio_regfile #(.NUM_EXT(NUM_EXT), .FULL_PROFILE(1'b0)) u_prio_regfile_red (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_write_i(write),
    .acc_secure_i(secure), .acc_waddr_i(waddr), .acc_be_i(be), .acc_wdata_i(wdata),
    .irq_ns_i(ns_bits), .acc_rdata_o(rdata_r), .prio_o(prio_r), .prio_upd_o(upd_r));

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // drive at a falling edge, drop at the next one; outputs are then one stage later
  task automatic access(input logic wr, input logic sec, input logic [11:0] addr,
                        input logic [3:0] ben, input logic [31:0] data);
    @(negedge clk);
    valid = 1'b1; write = wr; secure = sec; waddr = addr[11:2]; be = ben; wdata = data;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 full table zero", {31'b0, |prio_f}, 32'h0);
    chk("R1 reduced table zero", {31'b0, |prio_r}, 32'h0);
    chk("R1 strobe low", {30'b0, upd_f, upd_r}, 32'h0);
    chk("R1 rdata zero", rdata_f | rdata_r, 32'h0);

    for (int i = 0; i < NROW; i++) begin
      logic [113:0] row;
      row = TBL[i];
      access(row[113], row[112], row[111:100], row[99:96], row[95:64]);
      if (!row[113]) begin
        chk($sformatf("R%0d row %0d full", TAG[i], i), rdata_f, row[63:32]);
        chk($sformatf("R%0d row %0d reduced", TAG[i], i), rdata_r, row[31:0]);
      end
    end

    // R10 byte placement on the priority output
    chk("R10 prio_o vector 16 full", {24'h0, prio_f[8*16 +: 8]}, 32'hFF);
    chk("R10 prio_o vector 16 reduced", {24'h0, prio_r[8*16 +: 8]}, 32'hC0);
    chk("R10 prio_o vector 47 full", {24'h0, prio_f[8*47 +: 8]}, 32'hDE);
    chk("R7 prio_o vector 4 reduced", {24'h0, prio_r[8*4 +: 8]}, 32'h00);
    // R8 slots 0..3 untouched
    chk("R8 slots 0-3 full", prio_f[31:0], 32'h0);
    chk("R8 slots 0-3 reduced", prio_r[31:0], 32'h0);

    // R9 strobe on a changing write, visible with the new value (R10)
    access(1'b1, 1'b1, 12'h400, 4'h1, 32'h0000_0001);
    chk("R9 strobe after change full", {31'b0, upd_f}, 32'h1);
    chk("R9 strobe after change reduced", {31'b0, upd_r}, 32'h1);
    chk("R10 new value same cycle full", {24'h0, prio_f[8*16 +: 8]}, 32'h01);
    chk("R2 new value masked reduced", {24'h0, prio_r[8*16 +: 8]}, 32'h00);
    @(negedge clk);
    chk("R9 strobe one cycle only", {30'b0, upd_f, upd_r}, 32'h0);
    access(1'b1, 1'b1, 12'h400, 4'h1, 32'h0000_0001);
    chk("R9 no strobe on same value", {30'b0, upd_f, upd_r}, 32'h0);
    access(1'b1, 1'b0, 12'h400, 4'hF, 32'hFFFF_FFFF);
    chk("R9 no strobe on filtered write", {30'b0, upd_f, upd_r}, 32'h0);
    chk("R5 filtered write left vector 16", {24'h0, prio_f[8*16 +: 8]}, 32'h01);
    access(1'b1, 1'b1, 12'h408, 4'h0, 32'hFFFF_FFFF);
    chk("R3 no lanes enabled no strobe", {30'b0, upd_f, upd_r}, 32'h0);

    // R1 reset again clears written state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 1'b1, 12'h41C, 4'hF, 32'h0);
    chk("R1 after second reset full", rdata_f, 32'h0);
    chk("R1 after second reset table", {31'b0, |prio_f | |prio_r}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule